// File: doc/BRIEF.md
# Spread-Spectrum Complementary PWM Pair

This block drives two complementary switch outputs, a high-side output and a low-side output, from one clock. A free-running period counter and an 11-bit duty compare produce a raw waveform. A deadtime stage then removes a programmable number of cycles from the start of every high phase of each output, so the two outputs are never high at the same time.

To spread the emitted spectrum, the switching period alternates between a base period and a longer period, which is the base plus a small step. A 16-bit timebase sets how often the generator flips between the two. Each flip waits for the current PWM period to end.

Software programs the block through an 8-bit register write port with a 3-bit address. The period, step, duty and deadtime values go into staging registers, and the generator copies them into working shadows at the end of each period. The timebase high byte waits in a holding latch until the low byte arrives, so the 16-bit value changes in one step.

Top module: `dither_pwm_pair`

## Requirements
- R1: With the timebase at 0, the distance between successive rising edges of either output equals the programmed period P, in clock cycles.
- R2: In steady state the high-side output stays high for duty minus deadtime cycles, and the low-side output for P minus duty minus deadtime cycles.
- R3: The two outputs are never high in the same cycle.
- R4: A raw phase no longer than the deadtime produces no pulse at all on that output.
- R5: After reset the deadtime is 8 and period, step, duty and timebase are 0. Enabling with no writes keeps the high-side output low and raises the low-side output 8 cycles after enable.
- R6: With a non-zero timebase T and step S, every period is either P or P+S, and both lengths occur. The active length flips every T cycles, taking effect at the next period end.
- R7: With the timebase at 0, only period P is used, even when the step is non-zero.
- R8: A write to the timebase high byte (address 6) changes nothing until the low byte (address 7) is written. The low-byte write commits both bytes together.
- R9: Period, step, duty and deadtime writes take effect only at the end of the PWM period in progress.
- R10: While enable is low both outputs are low. On a new enable the counters restart from zero, so the high-side output first rises exactly deadtime cycles after enable (duty > deadtime).
- R11: Register map, 8-bit data: address 0 = P[7:0], address 1 bits 2:0 = P[10:8], address 2 bits 4:0 = step, address 3 = duty[7:0], address 4 bits 2:0 = duty[10:8], address 5 = deadtime, address 6 = timebase[15:8], address 7 = timebase[7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 8 | Register write data |
| outHi | output | 1 | High-side output |
| outLo | output | 1 | Low-side output |

## Verification
The hardest state to reach from the ports is a timebase high byte that sits in the holding latch while the committed timebase is still zero. At the outputs this looks exactly like the idle case until the low byte arrives. The stimulus runs with a non-zero step, writes only the high byte, and then observes twenty periods to show every length is still P. Only after that does it write the low byte and collect forty periods, which must contain both P and P+step and nothing else.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;
  localparam int PER_W  = 11;
  localparam int STEP_W = 5;
  localparam int DT_W   = 8;
  localparam int BYTE_W = 8;
  localparam int TB_W   = 2 * BYTE_W;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = PER_W + 1;
  localparam logic [DT_W-1:0] DT_RESET = DT_W'(8);

  typedef enum logic [ADDR_W-1:0] {
    REG_PER_LO  = 3'd0,
    REG_PER_HI  = 3'd1,
    REG_STEP    = 3'd2,
    REG_DUTY_LO = 3'd3,
    REG_DUTY_HI = 3'd4,
    REG_DEAD    = 3'd5,
    REG_TB_HI   = 3'd6,
    REG_TB_LO   = 3'd7
  } regSelT;

  typedef struct packed {
    logic             run;
    logic [CNT_W-1:0] period;
    logic [PER_W-1:0] duty;
    logic [DT_W-1:0]  dead;
  } pwmCtlT;
endpackage

// File: rtl/pwm_dither_ctrl.sv
module pwm_dither_ctrl
  import pwm_dither_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              periodEnd,
  output pwmCtlT            ctl
);
  logic [PER_W-1:0]  stPer, stDuty, shPer, shDuty;
  logic [STEP_W-1:0] stStep, shStep;
  logic [DT_W-1:0]   stDead, shDead;
  logic [BYTE_W-1:0] tbHiLatch;
  logic [TB_W-1:0]   tbVal, tbCnt;
  logic              wantB, useB;
  logic              loadShadow;

  // staging registers written by the byte port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stPer     <= '0;
      stStep    <= '0;
      stDuty    <= '0;
      stDead    <= DT_RESET;
      tbHiLatch <= '0;
      tbVal     <= '0;
    end else if (wrEn) begin
      case (regSelT'(wrAddr))
        REG_PER_LO:  stPer[BYTE_W-1:0]      <= wrData;
        REG_PER_HI:  stPer[PER_W-1:BYTE_W]  <= wrData[PER_W-BYTE_W-1:0];
        REG_STEP:    stStep                 <= wrData[STEP_W-1:0];
        REG_DUTY_LO: stDuty[BYTE_W-1:0]     <= wrData;
        REG_DUTY_HI: stDuty[PER_W-1:BYTE_W] <= wrData[PER_W-BYTE_W-1:0];
        REG_DEAD:    stDead                 <= wrData;
        REG_TB_HI:   tbHiLatch              <= wrData;
        REG_TB_LO:   tbVal                  <= {tbHiLatch, wrData};
        default: ;
      endcase
    end
  end

  // timebase: flips the wanted period every tbVal cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tbCnt <= '0;
      wantB <= 1'b0;
    end else if (!enable || tbVal == '0) begin
      tbCnt <= '0;
      wantB <= 1'b0;
    end else if (tbCnt >= tbVal - 1'b1) begin
      tbCnt <= '0;
      wantB <= ~wantB;
    end else begin
      tbCnt <= tbCnt + 1'b1;
    end
  end

  // working shadows, refreshed at period end or while idle
  assign loadShadow = periodEnd || !enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPer  <= '0;
      shStep <= '0;
      shDuty <= '0;
      shDead <= DT_RESET;
      useB   <= 1'b0;
    end else if (loadShadow) begin
      shPer  <= stPer;
      shStep <= stStep;
      shDuty <= stDuty;
      shDead <= stDead;
      useB   <= enable && wantB;
    end
  end

  always_comb begin
    ctl.run    = enable;
    ctl.period = useB ? ({1'b0, shPer} + {{(CNT_W-STEP_W){1'b0}}, shStep})
                      : {1'b0, shPer};
    ctl.duty   = shDuty;
    ctl.dead   = shDead;
  end

  a_r8_tb_hi_held: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == REG_TB_HI) |=> $stable(tbVal));

  a_r7_zero_tb_no_flip: assert property (@(posedge clk) disable iff (!rstN)
    (tbVal == '0) |=> !wantB);

  a_r9_shadow_mid_period: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !periodEnd) |=> ($stable(shPer) && $stable(shDuty) &&
                                $stable(shDead) && $stable(shStep)));

  a_r6_switch_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !periodEnd) |=> $stable(useB));
endmodule

// File: rtl/pwm_dither_datapath.sv
module pwm_dither_datapath
  import pwm_dither_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  pwmCtlT ctl,
  output logic   periodEnd,
  output logic   outHi,
  output logic   outLo
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cntInc;
  logic             rawTop, lastRaw;
  logic [DT_W-1:0]  holdCnt, age;

  assign cntInc    = {1'b0, cnt} + 1'b1;
  assign periodEnd = ctl.run && (cntInc >= {1'b0, ctl.period});
  assign rawTop    = cnt < {1'b0, ctl.duty};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (!ctl.run)       cnt <= '0;
    else if (periodEnd)      cnt <= '0;
    else                     cnt <= cntInc[CNT_W-1:0];
  end

  // age of the current raw level, saturating
  assign age = (rawTop == lastRaw) ? holdCnt : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastRaw <= 1'b0;
      holdCnt <= '0;
    end else if (!ctl.run) begin
      lastRaw <= 1'b0;
      holdCnt <= '0;
    end else begin
      lastRaw <= rawTop;
      if (rawTop != lastRaw)  holdCnt <= DT_W'(1);
      else if (holdCnt != '1) holdCnt <= holdCnt + 1'b1;
    end
  end

  assign outHi = ctl.run &&  rawTop && (age >= ctl.dead);
  assign outLo = ctl.run && !rawTop && (age >= ctl.dead);

  a_r3_never_both: assert property (@(posedge clk) disable iff (!rstN)
    !(outHi && outLo));

  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |-> (!outHi && !outLo));

  a_r1_count_in_period: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && ctl.period != '0) |-> (cnt < ctl.period));

  a_r2_gap_before_hi: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(outHi) && ctl.dead != '0) |-> $past(!outLo));

  a_r2_gap_before_lo: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(outLo) && ctl.dead != '0) |-> $past(!outHi));
endmodule

// File: rtl/dither_pwm_pair.sv
module dither_pwm_pair
  import pwm_dither_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  output logic              outHi,
  output logic              outLo
);
  pwmCtlT ctl;
  logic   periodEnd;

  pwm_dither_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .periodEnd (periodEnd),
    .ctl       (ctl)
  );

  pwm_dither_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .periodEnd (periodEnd),
    .outHi     (outHi),
    .outLo     (outLo)
  );
endmodule

// File: tb/dither_pwm_pair_tb_top.sv
module dither_pwm_pair_tb_top;
  logic       clk = 1'b0;
  logic       rstN, enable, wrEn;
  logic [2:0] wrAddr;
  logic [7:0] wrData;
  logic       outHi, outLo;

  dither_pwm_pair dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .outHi(outHi), .outLo(outLo)
  );

  always #5 clk = ~clk;

  int nChecks = 0, nErr = 0;
  bit done = 1'b0;

  // port monitor, sampled on the falling edge
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  nHi = 0, nLo = 0, runHi = 0, runLo = 0, lastHiW = -1, lastLoW = -1;
  int  lastRiseHi = -1, lastRiseLo = -1, overlap = 0;
  int  hiPer [256];
  int  loPer [256];
  bit  prevHi = 1'b0, prevLo = 1'b0;

  always @(negedge clk) begin
    if (outHi && outLo) overlap = overlap + 1;
    if (outHi && !prevHi) begin
      if (nHi > 0) hiPer[nHi % 256] = cyc - lastRiseHi;
      lastRiseHi = cyc;
      nHi = nHi + 1;
    end
    if (outLo && !prevLo) begin
      if (nLo > 0) loPer[nLo % 256] = cyc - lastRiseLo;
      lastRiseLo = cyc;
      nLo = nLo + 1;
    end
    if (outHi) runHi = runHi + 1;
    else begin
      if (prevHi) lastHiW = runHi;
      runHi = 0;
    end
    if (outLo) runLo = runLo + 1;
    else begin
      if (prevLo) lastLoW = runLo;
      runLo = 0;
    end
    prevHi = outHi;
    prevLo = outLo;
  end

  // period, duty, deadtime, expected high-side width, expected low-side width
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{ 20,  10,  2,   8,   8},
    '{ 40,  10,  0,  10,  30},
    '{ 30,  25,  3,  22,   2},
    '{ 50,   5,  4,   1,  41},
    '{100,  60, 10,  50,  30},
    '{ 12,   4,  1,   3,   7},
    '{600, 300, 10, 290, 290}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(input int addr, input int data);
    wrAddr = 3'(addr);
    wrData = 8'(data);
    wrEn   = 1'b1;
    cycles(1);
    wrEn   = 1'b0;
  endtask

  task automatic cfg(input int p, input int step, input int duty, input int dead);
    wr(0, p & 255);
    wr(1, p >> 8);
    wr(2, step);
    wr(3, duty & 255);
    wr(4, duty >> 8);
    wr(5, dead);
  endtask

  task automatic waitHi(input int target);
    while (nHi < target) cycles(1);
  endtask

  initial begin
    int n0, m0, cEn, c20, c24, cOther;
    rstN = 1'b0; enable = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    cycles(3);
    rstN = 1'b1;
    cycles(1);
    check(!outHi && !outLo, "R10 reset idle outputs low", {outHi, outLo}, 0);

    // R5: defaults only, deadtime 8 and duty 0
    cEn = cyc;
    enable = 1'b1;
    cycles(30);
    check(lastRiseLo - cEn == 8, "R5 default deadtime delay", lastRiseLo - cEn, 8);
    check(nHi == 0, "R5 zero duty keeps high side low", nHi, 0);

    // R1 R2 R11: table walk
    for (int v = 0; v < NV; v++) begin
      enable = 1'b0;
      cycles(1);
      cfg(VEC[v][0], 0, VEC[v][1], VEC[v][2]);
      wr(6, 0);
      wr(7, 0);
      enable = 1'b1;
      cycles(5 * VEC[v][0]);
      n0 = nHi; m0 = nLo;
      waitHi(n0 + 2);
      while (nLo < m0 + 2) cycles(1);
      check(lastHiW == VEC[v][3], "R2 high-side width", lastHiW, VEC[v][3]);
      check(lastLoW == VEC[v][4], "R2 low-side width", lastLoW, VEC[v][4]);
      check(hiPer[(nHi - 1) % 256] == VEC[v][0], "R1 R11 period length",
            hiPer[(nHi - 1) % 256], VEC[v][0]);
    end

    // R4: high phase of 3 under deadtime 5
    enable = 1'b0;
    cycles(1);
    cfg(20, 0, 3, 5);
    enable = 1'b1;
    cycles(60);
    n0 = nHi;
    cycles(100);
    check(nHi == n0, "R4 short pulse suppressed", nHi - n0, 0);
    check(lastLoW == 12, "R4 low side still switches", lastLoW, 12);
    check(loPer[(nLo - 1) % 256] == 20, "R1 low-side period", loPer[(nLo - 1) % 256], 20);

    // R9: period write lands at the next boundary
    enable = 1'b0;
    cycles(1);
    cfg(20, 0, 10, 1);
    enable = 1'b1;
    cycles(100);
    n0 = nHi;
    waitHi(n0 + 1);
    wr(0, 30);
    waitHi(n0 + 3);
    check(hiPer[(n0 + 1) % 256] == 20, "R9 current period kept", hiPer[(n0 + 1) % 256], 20);
    check(hiPer[(n0 + 2) % 256] == 30, "R9 new period next", hiPer[(n0 + 2) % 256], 30);

    // R7: step set, timebase zero
    enable = 1'b0;
    cycles(1);
    cfg(20, 4, 10, 1);
    wr(6, 0);
    wr(7, 0);
    enable = 1'b1;
    cycles(100);
    n0 = nHi;
    waitHi(n0 + 21);
    cOther = 0;
    for (int k = n0 + 1; k <= n0 + 20; k++) if (hiPer[k % 256] != 20) cOther++;
    check(cOther == 0, "R7 no dithering at zero timebase", cOther, 0);

    // R8: high byte alone must not start dithering
    wr(6, 1);
    n0 = nHi;
    waitHi(n0 + 21);
    cOther = 0;
    for (int k = n0 + 1; k <= n0 + 20; k++) if (hiPer[k % 256] != 20) cOther++;
    check(cOther == 0, "R8 latched high byte inert", cOther, 0);

    // R6: commit timebase 306
    wr(7, 50);
    cycles(50);
    n0 = nHi;
    waitHi(n0 + 41);
    c20 = 0; c24 = 0; cOther = 0;
    for (int k = n0 + 1; k <= n0 + 40; k++) begin
      if (hiPer[k % 256] == 20) c20++;
      else if (hiPer[k % 256] == 24) c24++;
      else cOther++;
    end
    check(cOther == 0, "R6 only two period lengths", cOther, 0);
    check(c20 > 0, "R6 base period present", c20, 1);
    check(c24 > 0, "R6 stepped period present", c24, 1);

    // R10: disable then restart from zero
    enable = 1'b0;
    #1;
    check(!outHi && !outLo, "R10 outputs low when disabled", {outHi, outLo}, 0);
    cycles(1);
    cfg(20, 0, 10, 3);
    wr(6, 0);
    wr(7, 0);
    cycles(5);
    n0 = nHi;
    cEn = cyc;
    enable = 1'b1;
    waitHi(n0 + 1);
    check(lastRiseHi - cEn == 3, "R10 restart timing", lastRiseHi - cEn, 3);

    check(overlap == 0, "R3 outputs never both high", overlap, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule